// File: doc/BRIEF.md
# LFSR-Counter Raster Timing Generator

This block produces horizontal sync, vertical sync and a display-enable window for a raster display. Line and frame position are held in two 16-bit linear feedback shift registers rather than binary counters, so the next-state logic of each counter is a single XOR level and a shift, whatever the raster size. Because the counters walk an LFSR sequence, every timing value the block is given is not a binary count. It is the LFSR state reached after the wanted number of steps from the all-ones seed. Every decision in the block is an equality match against one of these encoded values.

Software, or a register block outside this design, converts each timing figure into its LFSR code. The horizontal last-pixel code is the state after htotal−1 steps, and the vertical last-line code is the state after vtotal steps. The display window runs from (total − sync start) to that value plus the active size. The horizontal sync window runs from step 1 to pulse width + 1. The vertical sync window runs from step 0 to the pulse width. A pixel-rate enable advances the raster. A power-down request forces all timing outputs low. A depth selector reports whether 16-bit pixels are in use.

Top module: `lfsr_raster_timer`

## Requirements
- R1: While reset is held, both position counters sit at the seed state 0xFFFF and hsync, vsync, dispEn, blanked and pix16 are all low.
- R2: A counter step shifts the state left by one bit and places the XOR of old bits 15, 4, 2 and 1 into bit 0. A compare code C(n) is therefore the state reached after n such steps from 0xFFFF.
- R3: In a clock where pixEn is low, neither position changes and hsync, vsync and dispEn keep their values.
- R4: On an enabled clock where the horizontal position equals hLastCmp, the horizontal position reloads to 0xFFFF and the vertical position takes one step. A line is therefore n+1 pixels when hLastCmp = C(n).
- R5: On an enabled clock where a line ends and the vertical position equals vLastCmp, the vertical position reloads to 0xFFFF. A frame is therefore m+1 lines when vLastCmp = C(m).
- R6: After the enabled clock that consumes position (h, v), dispEn is high exactly when h lies in [a, b) and v lies in [c, d), where hStartCmp = C(a), hStopCmp = C(b), vStartCmp = C(c) and vStopCmp = C(d).
- R7: After the enabled clock that consumes position (h, v), hsync (active high) is high exactly when h lies in [p, q), with hsyncOnCmp = C(p) and hsyncOffCmp = C(q). vsync (active high) is high exactly when v lies in [r, s), with vsyncOnCmp = C(r) and vsyncOffCmp = C(s).
- R8: pwrDownReq = 1 selects power-down and 0 selects display on. One clock after power-down is requested, blanked is high and hsync, vsync and dispEn are low. The raster keeps counting, so the timing resumes in phase once power-down is released.
- R9: One clock after depthSel is driven, pix16 is high exactly when depthSel holds 8'h00, the 16-bit pixel selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixEn | input | 1 | Pixel-rate advance enable |
| pwrDownReq | input | 1 | 1 = power-down, 0 = display on |
| depthSel | input | 8 | Pixel depth select, 0 = 16-bit |
| hStartCmp | input | 16 | LFSR code of first active pixel |
| hStopCmp | input | 16 | LFSR code of first pixel after active area |
| vStartCmp | input | 16 | LFSR code of first active line |
| vStopCmp | input | 16 | LFSR code of first line after active area |
| hLastCmp | input | 16 | LFSR code of last pixel of a line |
| vLastCmp | input | 16 | LFSR code of last line of a frame |
| hsyncOnCmp | input | 16 | LFSR code where hsync rises |
| hsyncOffCmp | input | 16 | LFSR code where hsync falls |
| vsyncOnCmp | input | 16 | LFSR code where vsync rises |
| vsyncOffCmp | input | 16 | LFSR code where vsync falls |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| dispEn | output | 1 | Display-enable window |
| blanked | output | 1 | Power-down indication |
| pix16 | output | 1 | 16-bit pixel depth selected |

## Verification
The horizontal reload and the vertical reload fall in the same enabled clock at the last pixel of every frame. A zero front porch also puts the vertical display-window clear on that final line. The bench provokes both with small random rasters, run for more than two frames each, with irregular pixEn gaps and power-down spans. A binary step model, fed the same timing figures, predicts hsync, vsync and dispEn after every clock, so a wrong wrap or a missed vertical step shows up at the first pixel of the next frame.

// File: rtl/lfsr_timing_pkg.sv
package lfsr_timing_pkg;
  parameter int POS_W = 16;
  // feedback taps: bits 15, 4, 2, 1
  parameter logic [POS_W-1:0] TAP_MASK = 16'h8016;
  localparam logic [POS_W-1:0] SEED = '1;
  localparam int DEPTH_W = 8;

  typedef struct packed {
    logic hWrap;   // last pixel of the line is being consumed
    logic vWrap;   // last line of the frame ends on this pixel
  } posStrobe_t;

  function automatic logic [POS_W-1:0] lfsrNext(input logic [POS_W-1:0] s);
    return {s[POS_W-2:0], ^(s & TAP_MASK)};
  endfunction
endpackage

// File: rtl/raster_pos_dp.sv
module raster_pos_dp
  import lfsr_timing_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             pixEn,
  input  posStrobe_t       strobe,
  output logic [POS_W-1:0] hPos,
  output logic [POS_W-1:0] vPos
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hPos <= SEED;
      vPos <= SEED;
    end else if (pixEn) begin
      if (strobe.hWrap) begin
        hPos <= SEED;
        vPos <= strobe.vWrap ? SEED : lfsrNext(vPos);
      end else begin
        hPos <= lfsrNext(hPos);
      end
    end
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !pixEn |=> $stable(hPos) && $stable(vPos));

  p_hstep_r2: assert property (@(posedge clk) disable iff (!rstN)
    pixEn && !strobe.hWrap |=> hPos == lfsrNext($past(hPos)) && $stable(vPos));

  p_hwrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    pixEn && strobe.hWrap |=> hPos == SEED);

  p_vstep_r4: assert property (@(posedge clk) disable iff (!rstN)
    pixEn && strobe.hWrap && !strobe.vWrap |=> vPos == lfsrNext($past(vPos)));

  p_vwrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    pixEn && strobe.vWrap |=> vPos == SEED);

endmodule

// File: rtl/raster_match_ctrl.sv
module raster_match_ctrl
  import lfsr_timing_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             pixEn,
  input  logic [POS_W-1:0] hPos,
  input  logic [POS_W-1:0] vPos,
  input  logic [POS_W-1:0] hStartCmp,
  input  logic [POS_W-1:0] hStopCmp,
  input  logic [POS_W-1:0] vStartCmp,
  input  logic [POS_W-1:0] vStopCmp,
  input  logic [POS_W-1:0] hLastCmp,
  input  logic [POS_W-1:0] vLastCmp,
  input  logic [POS_W-1:0] hsyncOnCmp,
  input  logic [POS_W-1:0] hsyncOffCmp,
  input  logic [POS_W-1:0] vsyncOnCmp,
  input  logic [POS_W-1:0] vsyncOffCmp,
  output posStrobe_t       strobe,
  output logic             hActQ,
  output logic             vActQ,
  output logic             hsyncQ,
  output logic             vsyncQ
);

  localparam int NWIN = 4;
  localparam int W_HDE = 0;
  localparam int W_VDE = 1;
  localparam int W_HS  = 2;
  localparam int W_VS  = 3;

  logic [POS_W-1:0] winPos   [NWIN];
  logic [POS_W-1:0] winStart [NWIN];
  logic [POS_W-1:0] winStop  [NWIN];
  logic [NWIN-1:0]  winFlag;

  always_comb begin
    winPos[W_HDE]   = hPos;
    winPos[W_VDE]   = vPos;
    winPos[W_HS]    = hPos;
    winPos[W_VS]    = vPos;
    winStart[W_HDE] = hStartCmp;
    winStart[W_VDE] = vStartCmp;
    winStart[W_HS]  = hsyncOnCmp;
    winStart[W_VS]  = vsyncOnCmp;
    winStop[W_HDE]  = hStopCmp;
    winStop[W_VDE]  = vStopCmp;
    winStop[W_HS]   = hsyncOffCmp;
    winStop[W_VS]   = vsyncOffCmp;
  end

  // one set/clear flag per window; a stop match outranks a start match
  for (genvar i = 0; i < NWIN; i++) begin : g_win
    logic flagQ;
    logic setHit;
    logic clrHit;
    assign setHit = winPos[i] == winStart[i];
    assign clrHit = winPos[i] == winStop[i];
    always_ff @(posedge clk) begin
      if (!rstN)         flagQ <= 1'b0;
      else if (pixEn) begin
        if (clrHit)      flagQ <= 1'b0;
        else if (setHit) flagQ <= 1'b1;
      end
    end
    assign winFlag[i] = flagQ;
  end

  always_comb begin
    strobe.hWrap = hPos == hLastCmp;
    strobe.vWrap = strobe.hWrap && (vPos == vLastCmp);
  end

  assign hActQ  = winFlag[W_HDE];
  assign vActQ  = winFlag[W_VDE];
  assign hsyncQ = winFlag[W_HS];
  assign vsyncQ = winFlag[W_VS];

  p_de_edge_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(hActQ) || $fell(hActQ) || $rose(vActQ) || $fell(vActQ)) |-> $past(pixEn));

  p_sync_edge_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(hsyncQ) || $fell(hsyncQ) || $rose(vsyncQ) || $fell(vsyncQ)) |-> $past(pixEn));

  p_vwrap_line_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.vWrap |-> strobe.hWrap);

endmodule

// File: rtl/lfsr_raster_timer.sv
module lfsr_raster_timer
  import lfsr_timing_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               pixEn,
  input  logic               pwrDownReq,
  input  logic [DEPTH_W-1:0] depthSel,
  input  logic [POS_W-1:0]   hStartCmp,
  input  logic [POS_W-1:0]   hStopCmp,
  input  logic [POS_W-1:0]   vStartCmp,
  input  logic [POS_W-1:0]   vStopCmp,
  input  logic [POS_W-1:0]   hLastCmp,
  input  logic [POS_W-1:0]   vLastCmp,
  input  logic [POS_W-1:0]   hsyncOnCmp,
  input  logic [POS_W-1:0]   hsyncOffCmp,
  input  logic [POS_W-1:0]   vsyncOnCmp,
  input  logic [POS_W-1:0]   vsyncOffCmp,
  output logic               hsync,
  output logic               vsync,
  output logic               dispEn,
  output logic               blanked,
  output logic               pix16
);

  localparam logic [DEPTH_W-1:0] DEPTH_16 = '0;

  posStrobe_t       strobe;
  logic [POS_W-1:0] hPos;
  logic [POS_W-1:0] vPos;
  logic             hActQ, vActQ, hsyncQ, vsyncQ;
  logic             pdQ;
  logic             pix16Q;

  raster_pos_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .pixEn  (pixEn),
    .strobe (strobe),
    .hPos   (hPos),
    .vPos   (vPos)
  );

  raster_match_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .pixEn       (pixEn),
    .hPos        (hPos),
    .vPos        (vPos),
    .hStartCmp   (hStartCmp),
    .hStopCmp    (hStopCmp),
    .vStartCmp   (vStartCmp),
    .vStopCmp    (vStopCmp),
    .hLastCmp    (hLastCmp),
    .vLastCmp    (vLastCmp),
    .hsyncOnCmp  (hsyncOnCmp),
    .hsyncOffCmp (hsyncOffCmp),
    .vsyncOnCmp  (vsyncOnCmp),
    .vsyncOffCmp (vsyncOffCmp),
    .strobe      (strobe),
    .hActQ       (hActQ),
    .vActQ       (vActQ),
    .hsyncQ      (hsyncQ),
    .vsyncQ      (vsyncQ)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pdQ    <= 1'b0;
      pix16Q <= 1'b0;
    end else begin
      pdQ    <= pwrDownReq;
      pix16Q <= depthSel == DEPTH_16;
    end
  end

  assign hsync   = hsyncQ & ~pdQ;
  assign vsync   = vsyncQ & ~pdQ;
  assign dispEn  = hActQ & vActQ & ~pdQ;
  assign blanked = pdQ;
  assign pix16   = pix16Q;

  p_powerdown_r8: assert property (@(posedge clk) disable iff (!rstN)
    pwrDownReq |=> blanked && !hsync && !vsync && !dispEn);

  p_depth_r9: assert property (@(posedge clk) disable iff (!rstN)
    (depthSel == DEPTH_16) |=> pix16);

  p_reset_r1: assert property (@(posedge clk)
    !rstN |=> !hsync && !vsync && !dispEn && !blanked && !pix16);

endmodule

// File: tb/lfsr_raster_timer_test.sv
`timescale 1ns/1ps
module lfsr_raster_timer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pixEn = 1'b0;
  logic        pwrDownReq = 1'b0;
  logic [7:0]  depthSel = 8'h01;
  logic [15:0] hStartCmp, hStopCmp, vStartCmp, vStopCmp, hLastCmp, vLastCmp;
  logic [15:0] hsyncOnCmp, hsyncOffCmp, vsyncOnCmp, vsyncOffCmp;
  logic        hsync, vsync, dispEn, blanked, pix16;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  lfsr_raster_timer uut (
    .clk(clk), .rstN(rstN), .pixEn(pixEn), .pwrDownReq(pwrDownReq),
    .depthSel(depthSel),
    .hStartCmp(hStartCmp), .hStopCmp(hStopCmp),
    .vStartCmp(vStartCmp), .vStopCmp(vStopCmp),
    .hLastCmp(hLastCmp), .vLastCmp(vLastCmp),
    .hsyncOnCmp(hsyncOnCmp), .hsyncOffCmp(hsyncOffCmp),
    .vsyncOnCmp(vsyncOnCmp), .vsyncOffCmp(vsyncOffCmp),
    .hsync(hsync), .vsync(vsync), .dispEn(dispEn),
    .blanked(blanked), .pix16(pix16)
  );

  // bench-side encoder: state after n steps from all ones (R2)
  function automatic logic [15:0] codeAt(input int n);
    logic [15:0] s = 16'hFFFF;
    for (int k = 0; k < n; k++)
      s = {s[14:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
    return s;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // raster figures (binary) and model state
  int ht, vt, xds, xde, yds, yde, hsw, vsw;
  int hCur, vCur;
  logic eHs, eVs, eDe;

  task automatic loadConfig(input int hd, input int hf, input int hswIn, input int hb,
                            input int vd, input int vf, input int vswIn, input int vb);
    hsw = hswIn; vsw = vswIn;
    ht  = hd + hf + hsw + hb;
    vt  = vd + vf + vsw + vb;
    xds = ht - (hd + hf);  xde = xds + hd;
    yds = vt - (vd + vf);  yde = yds + vd;
    hStartCmp   = codeAt(xds);
    hStopCmp    = codeAt(xde);
    vStartCmp   = codeAt(yds);
    vStopCmp    = codeAt(yde);
    hLastCmp    = codeAt(ht - 1);
    vLastCmp    = codeAt(vt);
    hsyncOnCmp  = codeAt(1);
    hsyncOffCmp = codeAt(hsw + 1);
    vsyncOnCmp  = codeAt(0);
    vsyncOffCmp = codeAt(vsw);
  endtask

  task automatic runConfig(input int frames, input bit gaps);
    int cycles;
    logic [7:0] dsel;
    @(negedge clk);
    rstN = 1'b0; pixEn = 1'b0; pwrDownReq = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    // R1: reset state
    chk("R1 hsync", hsync, 1'b0);
    chk("R1 vsync", vsync, 1'b0);
    chk("R1 dispEn", dispEn, 1'b0);
    chk("R1 blanked", blanked, 1'b0);
    chk("R1 pix16", pix16, 1'b0);
    hCur = 0; vCur = 0; eHs = 0; eVs = 0; eDe = 0;
    cycles = frames * ht * (vt + 1) * (gaps ? 2 : 1);
    @(negedge clk); rstN = 1'b1;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      pixEn = gaps ? (($urandom % 4) != 0) : 1'b1;
      pwrDownReq = ((c / 29) % 5) == 4;
      dsel = (($urandom % 3) == 0) ? 8'h00 : 8'(1 + ($urandom % 255));
      depthSel = dsel;
      @(posedge clk);
      if (pixEn) begin
        // R6/R7 windows evaluated on the consumed position
        eHs = (hCur >= 1) && (hCur < hsw + 1);
        eVs = vCur < vsw;
        eDe = (hCur >= xds) && (hCur < xde) && (vCur >= yds) && (vCur < yde);
        // R4/R5 wrap model
        if (hCur == ht - 1) begin
          hCur = 0;
          vCur = (vCur == vt) ? 0 : vCur + 1;
        end else begin
          hCur = hCur + 1;
        end
      end
      #1;
      // R3 is covered by cycles with pixEn low: expectations hold
      chk(pixEn ? "R7 hsync" : "R3 hsync hold", hsync, eHs & ~pwrDownReq);
      chk(pixEn ? "R7 vsync" : "R3 vsync hold", vsync, eVs & ~pwrDownReq);
      chk(pixEn ? "R6 dispEn (R4 R5 wraps)" : "R3 dispEn hold", dispEn,
          eDe & ~pwrDownReq);
      chk("R8 blanked", blanked, pwrDownReq);
      chk("R9 pix16", pix16, dsel == 8'h00);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // directed: narrowest raster, zero vertical front porch so the vertical
    // display clear lands on the last line of the frame (R5, R6)
    loadConfig(2, 1, 1, 1, 1, 0, 1, 0);
    runConfig(3, 1'b0);
    // directed: same raster with pixEn gaps (R3)
    runConfig(2, 1'b1);
    for (int n = 0; n < 6; n++) begin
      loadConfig(2 + $urandom % 5, 1 + $urandom % 3, 1 + $urandom % 3, 1 + $urandom % 3,
                 1 + $urandom % 4, $urandom % 3, 1 + $urandom % 2, $urandom % 3);
      runConfig(2, n[0]);
    end
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

endmodule